// File: doc/BRIEF.md
# Hex Record Parser and Command Responder

This block takes a stream of ASCII characters, one per cycle when `in_valid` is high. It parses hex records that start with a colon and end with a carriage return. Each record is read in this order: a byte count, a 16-bit start address, a record type, up to sixteen payload bytes and a checksum byte. Every field is a pair of hexadecimal digits. The block adds up the bytes as they arrive and keeps the payload in a small buffer. Nothing is acted on until the terminating carriage return has been received.

Once a record is complete, the block checks the checksum and then acts on the record type. Depending on the type, it can write bytes one at a time to a programming back end, issue a single configuration command to that back end, or only update its own state. It then answers with exactly one status character: `.` for success, `X` for a rejected record and `R` for a programming refusal or failure. The back end answers each command with a done pulse, and a fail flag qualifies that pulse.

Top module: `hexrec_responder`

## Requirements
- R1: A record is accepted only in this form: ':' then count, address high, address low, type, payload and checksum, each as a pair of hex digits (0-9, A-F or a-f, high nibble first), then CR (0x0D). LF (0x0A) is ignored everywhere.
- R2: The sum modulo 256 of all record bytes, checksum included, must be 00h. On a mismatch the block answers 'X' (0x58) and issues no command.
- R3: A count above 16, a character that is not hex, CR or LF, or a CR before the checksum ends the record silently. A ':' arriving mid-record starts a new record. Characters outside a record are ignored.
- R4: A type 00 record that arrives before any type 02 record since reset is answered 'R' (0x52), and no command is issued.
- R5: After a type 02 record, a type 00 record issues one command per payload byte with op code 0, in payload order, at addresses AAAA+i (wrapping at 16 bits). Each command holds op, address and data until `cmd_done`. If every byte succeeds, the answer is '.' (0x2E). A count of zero is answered '.' at once.
- R6: If `cmd_fail` is high with `cmd_done` while bytes are being programmed, programming stops after that byte and the answer is 'R'.
- R7: A type 01 record is answered '.' and has no effect. A type 02 record is answered '.' and allows later programming.
- R8: A type 03 record whose first payload byte is 04h issues op code 1 (clear boot status).
- R9: A type 03 record with first byte 05h and second byte 00h, 01h or 02h issues op code 2, with `cmd_data` equal to the second byte. Any other second byte is answered 'X'.
- R10: A type 03 record with bytes 06h, 02h, 80h issues op code 3 with `cmd_data` 80h. Any other combination under 06h is answered 'X'. A back-end failure on any type 03 command is answered 'R', and success is answered '.'.
- R11: Any record type other than 00h to 03h, with a correct checksum, is answered 'X'.
- R12: Each completed record yields exactly one status. `st_valid` is a single-cycle pulse and is never high together with `cmd_valid`. Characters that arrive while the block is still carrying out a record are dropped.
- R13: Reset is synchronous and active high. It clears `cmd_valid` and `st_valid` and forgets any type 02 record already seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A character is present on `in_char` |
| in_char | input | 8 | ASCII input character |
| cmd_valid | output | 1 | Command to the back end is pending |
| cmd_op | output | 2 | 0 program byte, 1 clear boot status, 2 security bit, 3 six-clock mode |
| cmd_addr | output | 16 | Byte address for op 0 |
| cmd_data | output | 8 | Byte to program, security bit index, or 80h |
| cmd_done | input | 1 | Back end finished the pending command |
| cmd_fail | input | 1 | Qualifies `cmd_done`: the command failed |
| st_valid | output | 1 | Status character strobe |
| st_char | output | 8 | Status character: '.', 'X' or 'R' |

## Verification
Some properties are checked by assertions on every cycle. A command must hold its op, address and data until it is acknowledged. Programming must never be issued before a frequency record. Security-bit and clock-mode commands must carry legal operands. Status must be a lone single-cycle pulse with a legal code, and the framer must never deliver a record with a count above the limit. Other behaviour can only be shown by the bench scenarios:
- whether a checksum is accepted or rejected,
- silent aborts and resynchronisation on a colon,
- address order and 16-bit wrap,
- stopping at the first failed byte,
- dropping characters while a record is being carried out,
- forgetting the frequency record after a reset.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    localparam int unsigned MAX_BYTES = 16;
    localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int unsigned IDX_W     = $clog2(MAX_BYTES);
    localparam int unsigned ADDR_W    = 16;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_OK    = 8'h2E;
    localparam logic [7:0] CH_BAD   = 8'h58;
    localparam logic [7:0] CH_REF   = 8'h52;

    localparam logic [7:0] RT_DATA = 8'h00;
    localparam logic [7:0] RT_EOF  = 8'h01;
    localparam logic [7:0] RT_FREQ = 8'h02;
    localparam logic [7:0] RT_MISC = 8'h03;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_CLR_STATUS = 2'd1,
        OP_SEC_BIT    = 2'd2,
        OP_CLK6       = 2'd3
    } cmd_op_e;

    typedef struct packed {
        logic       sof;
        logic       eol;
        logic       bad;
        logic       byte_vld;
        logic [7:0] data;
    } token_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        rtype;
        logic              sum_ok;
    } rec_hdr_t;

    typedef enum logic [2:0] {
        F_IDLE, F_COUNT, F_ADDR_HI, F_ADDR_LO, F_TYPE, F_DATA, F_CSUM, F_EOL
    } frm_state_e;

    typedef enum logic [1:0] {
        E_IDLE, E_PROG, E_CMD
    } exe_state_e;

    function automatic logic is_hex(input logic [7:0] c);
        return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
               (c >= 8'h61 && c <= 8'h66);
    endfunction

    function automatic logic [3:0] hex_nib(input logic [7:0] c);
        logic [7:0] v;
        if (c <= 8'h39)      v = c - 8'h30;
        else if (c <= 8'h46) v = c - 8'h37;
        else                 v = c - 8'h57;
        return v[3:0];
    endfunction

endpackage

// File: rtl/hexrec_lexer.sv
module hexrec_lexer
    import hexrec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_char,
    output token_t     tok
);

    logic       phase;
    logic [3:0] hi_nib;

    always_ff @(posedge clk) begin
        if (rst) begin
            tok    <= '0;
            phase  <= 1'b0;
            hi_nib <= '0;
        end else begin
            tok <= '0;
            if (in_valid) begin
                if (in_char == CH_COLON) begin
                    tok.sof <= 1'b1;
                    phase   <= 1'b0;
                end else if (is_hex(in_char)) begin
                    if (!phase) begin
                        hi_nib <= hex_nib(in_char);
                        phase  <= 1'b1;
                    end else begin
                        tok.byte_vld <= 1'b1;
                        tok.data     <= {hi_nib, hex_nib(in_char)};
                        phase        <= 1'b0;
                    end
                end else if (in_char == CH_CR) begin
                    tok.eol <= 1'b1;
                    phase   <= 1'b0;
                end else if (in_char != CH_LF) begin
                    tok.bad <= 1'b1;
                    phase   <= 1'b0;
                end
            end
        end
    end

    // R1: one token kind per cycle at most
    assert_one_token_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tok.sof, tok.eol, tok.bad, tok.byte_vld}));

endmodule

// File: rtl/hexrec_framer.sv
module hexrec_framer
    import hexrec_pkg::*;
#(
    parameter int unsigned NBYTES = MAX_BYTES,
    parameter int unsigned CW     = CNT_W,
    parameter int unsigned IW     = IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  token_t                 tok,
    input  logic                   busy,
    output logic                   rec_valid,
    output rec_hdr_t               hdr,
    output logic [CW-1:0]          rec_cnt,
    output logic [NBYTES-1:0][7:0] rec_buf
);

    localparam logic [7:0] LIMIT = 8'(NBYTES);

    frm_state_e    state;
    logic [7:0]    sum;
    logic [CW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= F_IDLE;
            sum       <= '0;
            idx       <= '0;
            rec_valid <= 1'b0;
            hdr       <= '0;
            rec_cnt   <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (!busy) begin
                if (tok.sof) begin
                    state <= F_COUNT;
                    sum   <= '0;
                end else if (tok.bad) begin
                    state <= F_IDLE;
                end else if (tok.eol) begin
                    rec_valid <= (state == F_EOL);
                    state     <= F_IDLE;
                end else if (tok.byte_vld && state != F_IDLE) begin
                    sum <= sum + tok.data;
                    unique case (state)
                        F_COUNT: begin
                            if (tok.data > LIMIT) state <= F_IDLE;
                            else begin
                                rec_cnt <= tok.data[CW-1:0];
                                state   <= F_ADDR_HI;
                            end
                        end
                        F_ADDR_HI: begin
                            hdr.addr[15:8] <= tok.data;
                            state          <= F_ADDR_LO;
                        end
                        F_ADDR_LO: begin
                            hdr.addr[7:0] <= tok.data;
                            state         <= F_TYPE;
                        end
                        F_TYPE: begin
                            hdr.rtype <= tok.data;
                            idx       <= '0;
                            state     <= (rec_cnt == '0) ? F_CSUM : F_DATA;
                        end
                        F_DATA: begin
                            rec_buf[idx[IW-1:0]] <= tok.data;
                            idx                  <= idx + 1'b1;
                            if (idx == rec_cnt - 1'b1) state <= F_CSUM;
                        end
                        F_CSUM: begin
                            hdr.sum_ok <= (8'(sum + tok.data) == 8'h00);
                            state      <= F_EOL;
                        end
                        default: state <= F_IDLE;
                    endcase
                end
            end
        end
    end

    // R3: a delivered record never exceeds the payload limit
    assert_cnt_limit_R3: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_cnt <= CW'(NBYTES)));

    // R1: a record completes only on a carriage return
    assert_done_on_cr_R1: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(tok.eol));

endmodule

// File: rtl/hexrec_exec.sv
module hexrec_exec
    import hexrec_pkg::*;
#(
    parameter int unsigned NBYTES = MAX_BYTES,
    parameter int unsigned CW     = CNT_W,
    parameter int unsigned IW     = IDX_W,
    parameter int unsigned AW     = ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rec_valid,
    input  rec_hdr_t               hdr,
    input  logic [CW-1:0]          rec_cnt,
    input  logic [NBYTES-1:0][7:0] rec_buf,
    output logic                   busy,
    output logic                   cmd_valid,
    output cmd_op_e                cmd_op,
    output logic [AW-1:0]          cmd_addr,
    output logic [7:0]             cmd_data,
    input  logic                   cmd_done,
    input  logic                   cmd_fail,
    output logic                   st_valid,
    output logic [7:0]             st_char
);

    exe_state_e    state;
    logic          freq_seen;
    logic [CW-1:0] idx;
    logic [CW-1:0] idx_nxt;

    logic          misc_ok;
    cmd_op_e       misc_op;
    logic [7:0]    misc_data;

    assign busy    = (state != E_IDLE);
    assign idx_nxt = idx + 1'b1;

    always_comb begin
        misc_ok   = 1'b0;
        misc_op   = OP_CLR_STATUS;
        misc_data = 8'h00;
        if (rec_cnt >= CW'(1) && rec_buf[0] == 8'h04) begin
            misc_ok = 1'b1;
        end else if (rec_cnt >= CW'(2) && rec_buf[0] == 8'h05 && rec_buf[1] <= 8'h02) begin
            misc_ok   = 1'b1;
            misc_op   = OP_SEC_BIT;
            misc_data = rec_buf[1];
        end else if (rec_cnt >= CW'(3) && rec_buf[0] == 8'h06 &&
                     rec_buf[1] == 8'h02 && rec_buf[2] == 8'h80) begin
            misc_ok   = 1'b1;
            misc_op   = OP_CLK6;
            misc_data = 8'h80;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= E_IDLE;
            freq_seen <= 1'b0;
            idx       <= '0;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_PROG;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            st_valid  <= 1'b0;
            st_char   <= '0;
        end else begin
            st_valid <= 1'b0;
            unique case (state)
                E_IDLE: if (rec_valid) begin
                    st_valid <= 1'b1;
                    st_char  <= CH_BAD;
                    if (hdr.sum_ok) begin
                        unique case (hdr.rtype)
                            RT_DATA: begin
                                if (!freq_seen) st_char <= CH_REF;
                                else if (rec_cnt == '0) st_char <= CH_OK;
                                else begin
                                    st_valid  <= 1'b0;
                                    state     <= E_PROG;
                                    idx       <= '0;
                                    cmd_valid <= 1'b1;
                                    cmd_op    <= OP_PROG;
                                    cmd_addr  <= hdr.addr;
                                    cmd_data  <= rec_buf[0];
                                end
                            end
                            RT_EOF: st_char <= CH_OK;
                            RT_FREQ: begin
                                freq_seen <= 1'b1;
                                st_char   <= CH_OK;
                            end
                            RT_MISC: if (misc_ok) begin
                                st_valid  <= 1'b0;
                                state     <= E_CMD;
                                cmd_valid <= 1'b1;
                                cmd_op    <= misc_op;
                                cmd_addr  <= '0;
                                cmd_data  <= misc_data;
                            end
                            default: st_char <= CH_BAD;
                        endcase
                    end
                end
                E_PROG: if (cmd_done) begin
                    if (cmd_fail || idx_nxt == rec_cnt) begin
                        cmd_valid <= 1'b0;
                        st_valid  <= 1'b1;
                        st_char   <= cmd_fail ? CH_REF : CH_OK;
                        state     <= E_IDLE;
                    end else begin
                        idx      <= idx_nxt;
                        cmd_addr <= cmd_addr + 1'b1;
                        cmd_data <= rec_buf[idx_nxt[IW-1:0]];
                    end
                end
                E_CMD: if (cmd_done) begin
                    cmd_valid <= 1'b0;
                    st_valid  <= 1'b1;
                    st_char   <= cmd_fail ? CH_REF : CH_OK;
                    state     <= E_IDLE;
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    // R5: a pending command holds its fields until acknowledged
    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) &&
                                      $stable(cmd_addr) && $stable(cmd_data)));

    // R4: no byte programming before a frequency record
    assert_prog_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PROG) |-> freq_seen);

    // R9: security bit index stays within 0..2
    assert_sec_sel_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_SEC_BIT) |-> (cmd_data <= 8'h02));

    // R10: six-clock command always carries 80h
    assert_clk6_data_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_CLK6) |-> (cmd_data == 8'h80));

    // R12: status is a lone single-cycle pulse with a legal code
    assert_st_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        st_valid |=> !st_valid);
    assert_st_code_R12: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_char == CH_OK || st_char == CH_BAD || st_char == CH_REF));
    assert_st_cmd_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(st_valid && cmd_valid));

    // R13: reset clears both strobes
    assert_reset_clear_R13: assert property (@(posedge clk)
        rst |=> (!cmd_valid && !st_valid));

endmodule

// File: rtl/hexrec_responder.sv
module hexrec_responder
    import hexrec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_char,
    output logic        cmd_valid,
    output logic [1:0]  cmd_op,
    output logic [15:0] cmd_addr,
    output logic [7:0]  cmd_data,
    input  logic        cmd_done,
    input  logic        cmd_fail,
    output logic        st_valid,
    output logic [7:0]  st_char
);

    token_t                    tok;
    logic                      busy;
    logic                      rec_valid;
    rec_hdr_t                  hdr;
    logic [CNT_W-1:0]          rec_cnt;
    logic [MAX_BYTES-1:0][7:0] rec_buf;
    cmd_op_e                   op_enum;

    hexrec_lexer u_lexer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_char  (in_char),
        .tok      (tok)
    );

    hexrec_framer #(
        .NBYTES (MAX_BYTES),
        .CW     (CNT_W),
        .IW     (IDX_W)
    ) u_framer (
        .clk       (clk),
        .rst       (rst),
        .tok       (tok),
        .busy      (busy),
        .rec_valid (rec_valid),
        .hdr       (hdr),
        .rec_cnt   (rec_cnt),
        .rec_buf   (rec_buf)
    );

    hexrec_exec #(
        .NBYTES (MAX_BYTES),
        .CW     (CNT_W),
        .IW     (IDX_W),
        .AW     (ADDR_W)
    ) u_exec (
        .clk       (clk),
        .rst       (rst),
        .rec_valid (rec_valid),
        .hdr       (hdr),
        .rec_cnt   (rec_cnt),
        .rec_buf   (rec_buf),
        .busy      (busy),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_enum),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .cmd_done  (cmd_done),
        .cmd_fail  (cmd_fail),
        .st_valid  (st_valid),
        .st_char   (st_char)
    );

    assign cmd_op = op_enum;

endmodule

// File: tb/hexrec_responder_tb_top.sv
module hexrec_responder_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic [7:0]  cmd_data;
    logic        cmd_done = 1'b0;
    logic        cmd_fail = 1'b0;
    logic        st_valid;
    logic [7:0]  st_char;

    int          n_tests = 0;
    int          n_fail  = 0;
    string       cur_tag = "R13";
    logic [7:0]  exp_st [$];
    logic [25:0] exp_cmd [$];
    logic [7:0]  dbuf [16];
    logic        pend = 1'b0;
    int          bk_wait = 0;
    logic        fail_en = 1'b0;
    logic [15:0] fail_addr = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    hexrec_responder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_fail(cmd_fail),
        .st_valid(st_valid), .st_char(st_char)
    );

    // Monitor and back-end model: pops expected items and compares them
    always @(negedge clk) begin
        if (rst) begin
            cmd_done = 1'b0;
            cmd_fail = 1'b0;
            pend     = 1'b0;
        end else begin
            if (st_valid) begin
                n_tests++;
                if (exp_st.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s: unexpected status act=%c exp=none", cur_tag, st_char);
                end else begin
                    automatic logic [7:0] e = exp_st.pop_front();
                    if (st_char !== e) begin
                        n_fail++;
                        $display("FAIL %s: status act=%c exp=%c", cur_tag, st_char, e);
                    end
                end
            end
            if (cmd_done) begin
                cmd_done = 1'b0;
                cmd_fail = 1'b0;
                pend     = 1'b0;
            end else if (pend) begin
                if (bk_wait == 0) begin
                    cmd_done = 1'b1;
                    cmd_fail = fail_en && (cmd_op != 2'd0 || cmd_addr == fail_addr);
                end else bk_wait--;
            end
            if (cmd_valid && !pend) begin
                n_tests++;
                pend    = 1'b1;
                bk_wait = 2;
                if (exp_cmd.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s: unexpected cmd act=%h exp=none", cur_tag,
                             {cmd_op, cmd_addr, cmd_data});
                end else begin
                    automatic logic [25:0] e = exp_cmd.pop_front();
                    if ({cmd_op, cmd_addr, cmd_data} !== e) begin
                        n_fail++;
                        $display("FAIL %s: cmd act=%h exp=%h", cur_tag,
                                 {cmd_op, cmd_addr, cmd_data}, e);
                    end
                end
            end
        end
    end

    function automatic string hx(input logic [7:0] v, input bit lc);
        return lc ? $sformatf("%02x", v) : $sformatf("%02X", v);
    endfunction

    function automatic string mk(input int n, input logic [15:0] a, input logic [7:0] t,
                                 input logic [7:0] adj, input bit lc);
        logic [7:0] sum;
        string s;
        sum = 8'(n) + a[15:8] + a[7:0] + t;
        s = {":", hx(8'(n), lc), hx(a[15:8], lc), hx(a[7:0], lc), hx(t, lc)};
        for (int i = 0; i < n; i++) begin
            s   = {s, hx(dbuf[i % 16], lc)};
            sum = sum + dbuf[i % 16];
        end
        sum = 8'(-sum) + adj;
        return {s, hx(sum, lc), "\r\n"};
    endfunction

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_char  = s[i];
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_st.size() != 0 || exp_cmd.size() != 0 || pend) @(posedge clk);
        repeat (6) @(posedge clk);
    endtask

    task automatic exp_c(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
        exp_cmd.push_back({op, a, d});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        n_tests++;
        if (cmd_valid !== 1'b0 || st_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R13: strobes after reset act=%b%b exp=00", cmd_valid, st_valid);
        end
    endtask

    task automatic fill(input int base);
        for (int i = 0; i < 16; i++) dbuf[i] = 8'(base + 17 * i);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung act=timeout exp=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R4: data before any frequency record is refused
        cur_tag = "R4"; fill(3);
        exp_st.push_back("R");
        send_str(mk(2, 16'h0100, 8'h00, 8'h00, 0)); drain();

        // R7: frequency record enables programming
        cur_tag = "R7"; dbuf[0] = 8'h0B;
        exp_st.push_back(".");
        send_str(mk(1, 16'h0000, 8'h02, 8'h00, 0)); drain();

        // R5: three bytes programmed in order
        cur_tag = "R5"; fill(8'h40);
        for (int i = 0; i < 3; i++) exp_c(2'd0, 16'h1234 + 16'(i), dbuf[i]);
        exp_st.push_back(".");
        send_str(mk(3, 16'h1234, 8'h00, 8'h00, 0)); drain();

        // R5: zero-length data record
        exp_st.push_back(".");
        send_str(mk(0, 16'h0000, 8'h00, 8'h00, 0)); drain();

        // R2: checksum off by one
        cur_tag = "R2";
        exp_st.push_back("X");
        send_str(mk(4, 16'h2000, 8'h00, 8'h01, 0)); drain();

        // R7: end-of-file
        cur_tag = "R7";
        exp_st.push_back(".");
        send_str(":00000001FF\r\n"); drain();

        // R1: lowercase digits, 16 bytes, address wraps
        cur_tag = "R1"; fill(8'h9C);
        for (int i = 0; i < 16; i++) exp_c(2'd0, 16'hFFF8 + 16'(i), dbuf[i]);
        exp_st.push_back(".");
        send_str(mk(16, 16'hFFF8, 8'h00, 8'h00, 1)); drain();

        // R3: count of 17 aborts silently, then a valid record
        cur_tag = "R3";
        send_str(mk(17, 16'h0000, 8'h00, 8'h00, 0)); drain();
        send_str(":0300G012\r\n"); drain();
        send_str(":02000001\r\n"); drain();
        exp_st.push_back(".");
        send_str({":0200", mk(0, 16'h0000, 8'h01, 8'h00, 0)}); drain();

        // R6: failure on the second byte stops programming
        cur_tag = "R6"; fill(8'h11);
        fail_en = 1'b1; fail_addr = 16'h2001;
        exp_c(2'd0, 16'h2000, dbuf[0]);
        exp_c(2'd0, 16'h2001, dbuf[1]);
        exp_st.push_back("R");
        send_str(mk(4, 16'h2000, 8'h00, 8'h00, 0)); drain();
        fail_en = 1'b0;

        // R8: clear boot status
        cur_tag = "R8"; dbuf[0] = 8'h04; dbuf[1] = 8'h00;
        exp_c(2'd1, 16'h0000, 8'h00);
        exp_st.push_back(".");
        send_str(mk(2, 16'h0000, 8'h03, 8'h00, 0)); drain();

        // R9: security bit 1, then an illegal selection
        cur_tag = "R9"; dbuf[0] = 8'h05; dbuf[1] = 8'h01;
        exp_c(2'd2, 16'h0000, 8'h01);
        exp_st.push_back(".");
        send_str(mk(2, 16'h0000, 8'h03, 8'h00, 0)); drain();
        dbuf[1] = 8'h03;
        exp_st.push_back("X");
        send_str(mk(2, 16'h0000, 8'h03, 8'h00, 0)); drain();

        // R10: six-clock bit, wrong data, and back-end failure
        cur_tag = "R10"; dbuf[0] = 8'h06; dbuf[1] = 8'h02; dbuf[2] = 8'h80;
        exp_c(2'd3, 16'h0000, 8'h80);
        exp_st.push_back(".");
        send_str(mk(3, 16'h0000, 8'h03, 8'h00, 0)); drain();
        dbuf[2] = 8'h40;
        exp_st.push_back("X");
        send_str(mk(3, 16'h0000, 8'h03, 8'h00, 0)); drain();
        dbuf[2] = 8'h80; fail_en = 1'b1;
        exp_c(2'd3, 16'h0000, 8'h80);
        exp_st.push_back("R");
        send_str(mk(3, 16'h0000, 8'h03, 8'h00, 0)); drain();
        fail_en = 1'b0;

        // R11: unsupported type
        cur_tag = "R11";
        exp_st.push_back("X");
        send_str(mk(0, 16'h0000, 8'h05, 8'h00, 0)); drain();

        // R12: a record sent while eight bytes are programmed is dropped
        cur_tag = "R12"; fill(8'h21);
        for (int i = 0; i < 8; i++) exp_c(2'd0, 16'h0300 + 16'(i), dbuf[i]);
        exp_st.push_back(".");
        send_str(mk(8, 16'h0300, 8'h00, 8'h00, 0));
        send_str(":00000001FF\r\n");
        drain();

        // R13: reset forgets the frequency record
        cur_tag = "R13";
        do_reset();
        fill(5);
        exp_st.push_back("R");
        send_str(mk(1, 16'h0000, 8'h00, 8'h00, 0)); drain();

        n_tests++;
        if (exp_st.size() != 0 || exp_cmd.size() != 0) begin
            n_fail++;
            $display("FAIL R12: leftover expectations act=%0d/%0d exp=0/0",
                     exp_st.size(), exp_cmd.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule